// File: doc/BRIEF.md
# Clock Root Configuration Update Controller

This block controls one clock root. Software reaches it through a small word-addressed register port. Source select, pre-divider ratio, mode and the hardware-control flag are written into a shadow configuration, and the fractional M, N and D values go into shadow registers of their own. None of these writes reaches the running clock. The running clock takes the new setting only when software sets the commit bit in the command register. The block then runs a gated switch-over. First it waits for one edge of the old source, then it loads the active copy, then it waits for one edge of the new source. After that it clears the commit bit by itself. Software polls that bit as its acknowledgement.

Each source clock arrives as a slow level. The block synchronises the level and turns each of its transitions into a one-cycle edge pulse. The root output is a one-cycle tick on the system clock. The pre-divider counts both edges of the selected source, so it can divide by half-integer ratios.

The root runs while a downstream request is high or while software holds the force-on bit. A status bit reports whether the root is off. If a source never toggles, a timeout bounds each wait, so a commit always finishes in a fixed number of cycles.

Top module: `ckr_root_ctrl`

## Requirements
- R1: After reset, the command register (address 0x00) reads 0x8000_0000, the configuration register (0x04) reads 0, root_tick is low and every act_* output is 0.
- R2: The configuration register holds these fields: pre-divider at bits HID_W-1:0, source select at bits 10:8, mode at bits 13:12, hardware-control flag at bit 20. All other bits read 0. M (0x08), N (0x0C) and D (0x10) keep only their low MND_W bits.
- R3: Writing a shadow register does not change any act_* output or the root_tick period until a commit.
- R4: Command bits 4, 5, 6 and 7 read 1 exactly while the shadow configuration, N, M or D (in that bit order) differs from its active copy. They read 0 after a commit, and a shadow write equal to the active value leaves its bit at 0.
- R5: Writing 1 to command bit 0 starts a commit. Bit 0 reads 1 until the shadow values are active and then clears by itself, within 2*SW_TMO+8 cycles. Writing 0 to bit 0 has no effect.
- R6: From the second cycle after the commit write until bit 0 clears, root_tick stays low and command bit 31 (root off) reads 1.
- R7: With pre-divider value h, root_tick pulses once every h+1 edges of the selected source when h>0, and once every 2 edges when h=0. Both rising and falling edges count as edges, so for a source level with half-period P cycles the tick period is P*(h+1) or 2P.
- R8: Command bit 1 (force on) keeps the root running with clk_req low. Bit 31 reads 0 within 2 cycles of setting bit 1. Clearing bit 1 while clk_req is low turns the root off and stops the ticks.
- R9: With force on clear, clk_req high runs the root and clk_req low stops it.
- R10: If the selected source never toggles, the commit still completes within the R5 budget, and no tick appears while that source stays selected.
- R11: root_tick follows the edges of the source whose index sits in the active source-select field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| src_lvl | input | NSRC | Source clock levels, asynchronous |
| clk_req | input | 1 | Downstream request to run the root |
| root_tick | output | 1 | One-cycle pulse per divided root period |
| root_off | output | 1 | High while the root is not running |
| act_src | output | 3 | Active source select |
| act_div | output | HID_W | Active pre-divider value |
| act_mode | output | 2 | Active mode field |
| act_hwctl | output | 1 | Active hardware-control flag |
| act_m | output | MND_W | Active M value |
| act_n | output | MND_W | Active N value |
| act_d | output | MND_W | Active D value |

## Verification
If the switch sequencer gets stuck in a wrong state, the commit bit never clears. The poll shows this within the commit budget, and it also leaves the root reporting off. If the active copy is loaded at the wrong moment, act_* or the measured tick period changes before the commit bit is written. The bench sees that at the next period measurement, a few dozen cycles later. A wrong divider count shows as a tick interval that misses P*(h+1) on the first full period after commit.

// File: rtl/ckr_pkg.sv
package ckr_pkg;
    localparam int SEL_W      = 3;
    localparam int MODE_W     = 2;
    localparam int NSEL       = 1 << SEL_W;
    localparam int SEL_LSB    = 8;
    localparam int MODE_LSB   = 12;
    localparam int HWCTL_BIT  = 20;
    localparam int BIT_COMMIT = 0;
    localparam int BIT_FORCE  = 1;
    localparam int BIT_DIRTY  = 4;
    localparam int BIT_OFF    = 31;

    localparam logic [4:0] ADR_CMD = 5'h00;
    localparam logic [4:0] ADR_CFG = 5'h04;
    localparam logic [4:0] ADR_M   = 5'h08;
    localparam logic [4:0] ADR_N   = 5'h0C;
    localparam logic [4:0] ADR_D   = 5'h10;

    typedef struct packed {
        logic              hwctl;
        logic [MODE_W-1:0] mode;
        logic [SEL_W-1:0]  sel;
    } route_t;

    typedef enum logic [1:0] {
        SW_IDLE  = 2'd0,
        SW_DRAIN = 2'd1,
        SW_ARM   = 2'd2
    } sw_state_e;

    // Last count value of the edge counter for pre-divider value h
    function automatic int unsigned last_count(int unsigned h);
        return (h == 0) ? 1 : h;
    endfunction
endpackage

// File: rtl/ckr_edge_sync.sv
module ckr_edge_sync
    import ckr_pkg::*;
#(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NSRC-1:0] src_lvl,
    output logic [NSEL-1:0] src_edge
);
    for (genvar i = 0; i < NSEL; i++) begin : g_src
        if (i < NSRC) begin : g_live
            logic [2:0] sh;
            always_ff @(posedge clk) begin
                if (rst) sh <= '0;
                else     sh <= {sh[1:0], src_lvl[i]};
            end
            assign src_edge[i] = sh[2] ^ sh[1];
        end else begin : g_dead
            assign src_edge[i] = 1'b0;
        end
    end
endmodule

// File: rtl/ckr_regs.sv
module ckr_regs
    import ckr_pkg::*;
#(
    parameter int HID_W = 5,
    parameter int MND_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [4:0]       addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             load,
    input  logic             done,
    input  logic             root_off,
    output logic             upd,
    output logic             force_en,
    output route_t           act_route,
    output logic [HID_W-1:0] act_div,
    output logic [MND_W-1:0] act_mnd [3]
);
    // mnd index: 0 = M, 1 = N, 2 = D
    route_t           sh_route;
    logic [HID_W-1:0] sh_div;
    logic [MND_W-1:0] sh_mnd [3];
    logic [3:0]       dirty;
    logic [4:0]       mnd_adr [3];

    assign mnd_adr[0] = ADR_M;
    assign mnd_adr[1] = ADR_N;
    assign mnd_adr[2] = ADR_D;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_route <= '0;
            sh_div   <= '0;
            force_en <= 1'b0;
            upd      <= 1'b0;
        end else begin
            if (we && addr == ADR_CFG) begin
                sh_div         <= wdata[HID_W-1:0];
                sh_route.sel   <= wdata[SEL_LSB +: SEL_W];
                sh_route.mode  <= wdata[MODE_LSB +: MODE_W];
                sh_route.hwctl <= wdata[HWCTL_BIT];
            end
            if (we && addr == ADR_CMD) begin
                force_en <= wdata[BIT_FORCE];
            end
            if (done)
                upd <= 1'b0;
            else if (we && addr == ADR_CMD && wdata[BIT_COMMIT])
                upd <= 1'b1;
        end
    end

    for (genvar k = 0; k < 3; k++) begin : g_mnd
        always_ff @(posedge clk) begin
            if (rst) begin
                sh_mnd[k]  <= '0;
                act_mnd[k] <= '0;
            end else begin
                if (we && addr == mnd_adr[k]) sh_mnd[k] <= wdata[MND_W-1:0];
                if (load) act_mnd[k] <= sh_mnd[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_route <= '0;
            act_div   <= '0;
        end else if (load) begin
            act_route <= sh_route;
            act_div   <= sh_div;
        end
    end

    assign dirty = {sh_mnd[2] != act_mnd[2], sh_mnd[0] != act_mnd[0],
                    sh_mnd[1] != act_mnd[1],
                    (sh_route != act_route) || (sh_div != act_div)};

    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CMD: begin
                rdata[BIT_OFF]            = root_off;
                rdata[BIT_DIRTY +: 4]     = dirty;
                rdata[BIT_FORCE]          = force_en;
                rdata[BIT_COMMIT]         = upd;
            end
            ADR_CFG: begin
                rdata[HID_W-1:0]          = sh_div;
                rdata[SEL_LSB +: SEL_W]   = sh_route.sel;
                rdata[MODE_LSB +: MODE_W] = sh_route.mode;
                rdata[HWCTL_BIT]          = sh_route.hwctl;
            end
            ADR_M: rdata[MND_W-1:0] = sh_mnd[0];
            ADR_N: rdata[MND_W-1:0] = sh_mnd[1];
            ADR_D: rdata[MND_W-1:0] = sh_mnd[2];
            default: rdata = '0;
        endcase
    end

    // R3: active copy only moves on a load from the sequencer
    assert_active_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(act_div) && $stable(act_route)));
    // R5: pending commit stays pending until the sequencer reports done
    assert_commit_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (upd && !done) |=> upd);
    // R4: right after a load the active copy matches what the shadow held
    assert_load_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (load && !(we && addr == ADR_CFG)) |=> dirty[0] == 1'b0);
endmodule

// File: rtl/ckr_switch.sv
module ckr_switch
    import ckr_pkg::*;
#(
    parameter int SW_TMO = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            upd,
    input  logic            edge_act,
    output logic            load,
    output logic            done,
    output logic            gate
);
    localparam int TMO_W = $clog2(SW_TMO + 1);
    localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(SW_TMO - 1);

    sw_state_e        state;
    logic [TMO_W-1:0] tmo;
    logic             step;

    assign step = edge_act || (tmo == TMO_LAST);
    assign load = (state == SW_DRAIN) && step;
    assign done = (state == SW_ARM) && step;
    assign gate = (state != SW_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SW_IDLE;
            tmo   <= '0;
        end else begin
            case (state)
                SW_IDLE: begin
                    tmo <= '0;
                    if (upd) state <= SW_DRAIN;
                end
                SW_DRAIN, SW_ARM: begin
                    if (step) begin
                        tmo   <= '0;
                        state <= (state == SW_DRAIN) ? SW_ARM : SW_IDLE;
                    end else begin
                        tmo <= tmo + 1'b1;
                    end
                end
                default: state <= SW_IDLE;
            endcase
        end
    end

    // R10: each wait is bounded by the timeout
    assert_wait_bound_R10: assert property (@(posedge clk) disable iff (rst)
        gate |-> (tmo < TMO_W'(SW_TMO)));
    // R5: a load is always followed by the arming wait
    assert_load_then_arm_R5: assert property (@(posedge clk) disable iff (rst)
        load |=> (state == SW_ARM));
endmodule

// File: rtl/ckr_hdiv.sv
module ckr_hdiv
    import ckr_pkg::*;
#(
    parameter int HID_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             edge_in,
    input  logic [HID_W-1:0] div,
    output logic             tick
);
    localparam int CNT_W = HID_W + 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    assign last = CNT_W'(last_count(int'(div)));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (edge_in) begin
            tick <= (cnt == last);
            cnt  <= (cnt == last) ? '0 : cnt + 1'b1;
        end else begin
            tick <= 1'b0;
        end
    end

    // R7: a tick coincides with the counter restarting
    assert_tick_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        tick |-> (cnt == '0));
endmodule

// File: rtl/ckr_root_ctrl.sv
module ckr_root_ctrl
    import ckr_pkg::*;
#(
    parameter int NSRC   = 4,
    parameter int HID_W  = 5,
    parameter int MND_W  = 8,
    parameter int SW_TMO = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic [4:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NSRC-1:0]  src_lvl,
    input  logic             clk_req,
    output logic             root_tick,
    output logic             root_off,
    output logic [2:0]       act_src,
    output logic [HID_W-1:0] act_div,
    output logic [1:0]       act_mode,
    output logic             act_hwctl,
    output logic [MND_W-1:0] act_m,
    output logic [MND_W-1:0] act_n,
    output logic [MND_W-1:0] act_d
);
    logic [NSEL-1:0]  src_edge;
    logic             upd, force_en, load, done, gate, run;
    route_t           act_route;
    logic [MND_W-1:0] act_mnd [3];

    ckr_edge_sync #(.NSRC(NSRC)) u_sync (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .src_edge(src_edge)
    );

    ckr_regs #(.HID_W(HID_W), .MND_W(MND_W)) u_regs (
        .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .load(load), .done(done),
        .root_off(root_off), .upd(upd), .force_en(force_en),
        .act_route(act_route), .act_div(act_div), .act_mnd(act_mnd)
    );

    ckr_switch #(.SW_TMO(SW_TMO)) u_switch (
        .clk(clk), .rst(rst), .upd(upd), .edge_act(src_edge[act_route.sel]),
        .load(load), .done(done), .gate(gate)
    );

    assign run = (force_en || clk_req) && !gate;

    ckr_hdiv #(.HID_W(HID_W)) u_div (
        .clk(clk), .rst(rst), .run(run), .edge_in(src_edge[act_route.sel]),
        .div(act_div), .tick(root_tick)
    );

    always_ff @(posedge clk) begin
        if (rst) root_off <= 1'b1;
        else     root_off <= !run;
    end

    assign act_src   = act_route.sel;
    assign act_mode  = act_route.mode;
    assign act_hwctl = act_route.hwctl;
    assign act_m     = act_mnd[0];
    assign act_n     = act_mnd[1];
    assign act_d     = act_mnd[2];

    // R6: no tick leaves the root while the switch-over gate is closed
    assert_gated_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        gate |=> !root_tick);
    // R8: forcing on with the sequencer idle brings the root up
    assert_force_on_R8: assert property (@(posedge clk) disable iff (rst)
        (force_en && !gate) |=> !root_off);
    // R9: with neither request nor force the root reports off
    assert_idle_off_R9: assert property (@(posedge clk) disable iff (rst)
        (!force_en && !clk_req) |=> root_off);
endmodule

// File: tb/test_ckr_root_ctrl.sv
`timescale 1ns/1ps
module test_ckr_root_ctrl;
    localparam int NSRC = 4, HID_W = 5, MND_W = 8, SW_TMO = 64;
    localparam int BUDGET = 2 * SW_TMO + 8;
    localparam int HP [4] = '{3, 5, 4, 7};

    logic             clk = 1'b0, rst = 1'b1;
    logic             bus_we = 1'b0;
    logic [4:0]       bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic [31:0]      bus_rdata;
    logic [NSRC-1:0]  src_lvl = '0;
    logic             clk_req = 1'b0;
    logic             root_tick, root_off, act_hwctl;
    logic [2:0]       act_src;
    logic [HID_W-1:0] act_div;
    logic [1:0]       act_mode;
    logic [MND_W-1:0] act_m, act_n, act_d;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    ckr_root_ctrl #(.NSRC(NSRC), .HID_W(HID_W), .MND_W(MND_W), .SW_TMO(SW_TMO))
    i_ckr_root_ctrl (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_lvl(src_lvl),
        .clk_req(clk_req), .root_tick(root_tick), .root_off(root_off),
        .act_src(act_src), .act_div(act_div), .act_mode(act_mode),
        .act_hwctl(act_hwctl), .act_m(act_m), .act_n(act_n), .act_d(act_d)
    );

    always #5 clk = ~clk;

    int scnt [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int s = 0; s < NSRC; s++) begin
            if (scnt[s] == HP[s] - 1) begin
                scnt[s] <= 0;
                src_lvl[s] <= ~src_lvl[s];
            end else begin
                scnt[s] <= scnt[s] + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    // Commit with the given force bit; checks gating and the cycle budget
    task automatic commit(input bit frc);
        logic [31:0] c;
        int k = 0;
        wr(5'h00, 32'h1 | (32'(frc) << 1));
        forever begin
            rd(5'h00, c);
            if (!c[0]) break;
            if (k >= 2) begin
                if (root_tick) chk(0, "R6 tick during commit", 1, 0);
                if (!c[31]) chk(0, "R6 root off during commit", 0, 1);
            end
            if (k > BUDGET) break;
            @(negedge clk);
            k++;
        end
        chk(k <= BUDGET, "R5 commit self-clears within budget", k, BUDGET);
    endtask

    task automatic period(output int p);
        int w = 0;
        p = 0;
        while (!root_tick && w < 400) begin @(negedge clk); w++; end
        @(negedge clk); p = 1;
        while (!root_tick && p < 400) begin @(negedge clk); p++; end
    endtask

    task automatic count_ticks(input int cyc, output int n);
        n = 0;
        for (int j = 0; j < cyc; j++) begin
            @(negedge clk);
            if (root_tick) n++;
        end
    endtask

    // {source, pre-divider, expected tick period in cycles}
    localparam logic [15:0] VEC [11] = '{
        {3'd0, 5'd0, 8'd6},  {3'd0, 5'd1, 8'd6},  {3'd0, 5'd2, 8'd9},
        {3'd0, 5'd3, 8'd12}, {3'd0, 5'd4, 8'd15}, {3'd0, 5'd5, 8'd18},
        {3'd0, 5'd6, 8'd21}, {3'd0, 5'd7, 8'd24}, {3'd1, 5'd2, 8'd15},
        {3'd2, 5'd5, 8'd24}, {3'd3, 5'd0, 8'd14}
    };

    initial begin
        logic [31:0] r, prev_cfg, cfg;
        int p, n;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        rd(5'h00, r); chk(r == 32'h8000_0000, "R1 command reset", r, 32'h8000_0000);
        rd(5'h04, r); chk(r == 0, "R1 config reset", r, 0);
        chk(root_tick == 0, "R1 tick reset", root_tick, 0);
        chk({act_src, act_div, act_mode, act_hwctl, act_m, act_n, act_d} == 0,
            "R1 active outputs reset", act_div, 0);

        clk_req = 1'b1;
        prev_cfg = 0;
        for (int i = 0; i < 11; i++) begin
            cfg = (32'(VEC[i][15:13]) << 8) | 32'(VEC[i][12:8]);
            wr(5'h04, cfg);
            rd(5'h00, r);
            chk(r[4] == (cfg != prev_cfg), "R4 config dirty flag", r[4], cfg != prev_cfg);
            commit(0);
            chk(act_src == VEC[i][15:13], "R11 active source", act_src, VEC[i][15:13]);
            chk(act_div == VEC[i][12:8], "R5 active divider", act_div, VEC[i][12:8]);
            period(p);
            chk(p == int'(VEC[i][7:0]), "R7 tick period", p, VEC[i][7:0]);
            prev_cfg = cfg;
        end

        // R8 / R9: request and force
        clk_req = 1'b0;
        repeat (4) @(negedge clk);
        rd(5'h00, r); chk(r[31] == 1, "R9 off without request", r[31], 1);
        count_ticks(60, n); chk(n == 0, "R9 no ticks without request", n, 0);
        wr(5'h00, 32'h2);
        @(negedge clk);
        rd(5'h00, r); chk(r[31] == 0, "R8 force brings root on", r[31], 0);
        period(p); chk(p == 14, "R8 forced root ticks", p, 14);
        wr(5'h00, 32'h0);
        repeat (2) @(negedge clk);
        rd(5'h00, r); chk(r[31] == 1, "R8 force cleared root off", r[31], 1);
        count_ticks(60, n); chk(n == 0, "R8 no ticks after force clear", n, 0);
        clk_req = 1'b1;
        repeat (2) @(negedge clk);
        rd(5'h00, r); chk(r[31] == 0, "R9 request runs root", r[31], 0);

        // R5: writing 0 to the commit bit does nothing
        wr(5'h04, 32'h0000_0001);
        wr(5'h00, 32'h0);
        repeat (3) @(negedge clk);
        rd(5'h00, r); chk(r[0] == 0, "R5 zero write no commit", r[0], 0);
        chk(act_src == 3 && act_div == 0, "R5 zero write keeps active", act_div, 0);

        // R10: dead source
        wr(5'h04, 32'h0000_0500);
        commit(0);
        chk(act_src == 5, "R10 dead source selected", act_src, 5);
        count_ticks(100, n); chk(n == 0, "R10 no ticks from dead source", n, 0);

        // R3 / R4: shadow isolation and dirty bits
        wr(5'h04, 32'h0);
        commit(0);
        period(p); chk(p == 6, "R3 baseline period", p, 6);
        wr(5'h04, 32'h0010_2107);
        rd(5'h00, r); chk(r[7:4] == 4'h1, "R4 dirty after config", r[7:4], 1);
        chk(act_div == 0 && act_src == 0, "R3 active unchanged", act_div, 0);
        period(p); chk(p == 6, "R3 period unchanged before commit", p, 6);
        wr(5'h08, 32'h33);
        rd(5'h00, r); chk(r[7:4] == 4'h5, "R4 dirty M bit 6", r[7:4], 5);
        wr(5'h0C, 32'h11);
        rd(5'h00, r); chk(r[7:4] == 4'h7, "R4 dirty N bit 5", r[7:4], 7);
        wr(5'h10, 32'h22);
        rd(5'h00, r); chk(r[7:4] == 4'hF, "R4 dirty D bit 7", r[7:4], 15);
        chk(act_m == 0 && act_n == 0 && act_d == 0, "R3 MND unchanged", act_m, 0);
        commit(0);
        rd(5'h00, r); chk(r[7:4] == 4'h0, "R4 dirty cleared by commit", r[7:4], 0);
        chk({act_m, act_n, act_d} == 24'h331122, "R5 MND active", {act_m, act_n, act_d}, 24'h331122);
        chk(act_mode == 2 && act_hwctl == 1, "R5 mode and hwctl active", act_mode, 2);
        period(p); chk(p == 40, "R7 period after commit", p, 40);
        wr(5'h04, 32'h0010_2107);
        rd(5'h00, r); chk(r[4] == 0, "R4 equal write stays clean", r[4], 0);

        // R2: field layout
        wr(5'h04, 32'hFFFF_FFFF);
        rd(5'h04, r); chk(r == 32'h0010_371F, "R2 config field mask", r, 32'h0010_371F);
        wr(5'h08, 32'hFFFF_FFFF);
        rd(5'h08, r); chk(r == 32'hFF, "R2 M width", r, 32'hFF);
        chk(act_div == 7, "R3 active kept after junk write", act_div, 7);

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=0x1 expected=0x0");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule